// File: doc/BRIEF.md
# Boundary-Scan Change Monitor

This block is a JTAG test-access-port master for a chain that holds a single device. It generates TCK from the system clock through a divider, drives TMS and TDI, and samples TDO. A command can read the device's 32-bit identification word. Other commands load a sample-type instruction and then capture the device's boundary-scan register over and over, comparing each capture with the one before it. For every bit that changed, its index is sent out on a valid/ready stream.

Some boundary bits toggle without any outside stimulus. A learning mode adds each bit it sees change to a suppression mask. Masked bits are never reported again. A list command streams out every masked index. The instruction opcode, the instruction length and the boundary-register length are inputs, so they can be changed at run time. They must be held steady while a command is running. A user probes a board pin and reads back the boundary index that moved.

Top module: `jtag_bscan_watch`

## Requirements
- R1: After reset, busy, tck and ev_valid are low and the suppression mask is empty, so a list command right after reset emits no index.
- R2: Command code 1 (info) holds TMS high for 5 TCK cycles and then moves the TAP to Shift-DR. It shifts in 32 bits LSB first, presents them on idcode with a one-cycle id_valid pulse, and leaves the TAP in Run-Test/Idle.
- R3: Command codes 2 (monitor) and 3 (learn) first shift cfg_opcode into the instruction register, LSB first, over cfg_ir_len bits. After Update-IR the device's instruction register holds cfg_opcode.
- R4: The first capture after a monitor or learn command only seeds the stored previous values and emits no index, even if the captured bits differ from the stored ones.
- R5: In monitor mode, each capture emits the index of every unmasked bit that differs from the previous capture, in ascending order. The first and the last index of the register are included.
- R6: In learn mode, a changed bit is emitted once and added to the mask. A masked bit is never emitted again in either mode.
- R7: Command code 4 (list) emits every masked index in ascending order and then drops busy.
- R8: While ev_valid is high and ev_ready is low, ev_valid, ev_idx and tck hold. No change index is lost.
- R9: Each capture shifts exactly cfg_bsr_len bits. With a shorter length, index cfg_bsr_len-1 is still reported.
- R10: Command code 5 (stop) forces busy and tck low on the next cycle. Any other command that arrives while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd | input | 3 | 1 info, 2 monitor, 3 learn, 4 list, 5 stop |
| cfg_opcode | input | IR_MAX | Instruction shifted before capturing |
| cfg_ir_len | input | clog2(IR_MAX+1) | Instruction register length |
| cfg_bsr_len | input | clog2(BSR_MAX+1) | Boundary register length |
| busy | output | 1 | A command is running |
| tck | output | 1 | Test clock |
| tms | output | 1 | Test mode select |
| tdi | output | 1 | Test data to the device |
| tdo | input | 1 | Test data from the device |
| ev_valid | output | 1 | Index available |
| ev_ready | input | 1 | Consumer accepts the index |
| ev_idx | output | clog2(BSR_MAX) | Changed or masked bit index |
| idcode | output | IDW | Identification word read by info |
| id_valid | output | 1 | One-cycle pulse when idcode is updated |

## Verification
Two functions can meet in the same cycle. The first pair is a change report and consumer back-pressure. The bench holds ev_ready low while two bits change between captures. It then checks that tck, ev_valid and ev_idx stay frozen over many cycles, and that both indices arrive once ready returns. The second pair is a new command and a running scan. An info command is issued in the middle of monitoring, and the bench judges it ignored when no id_valid pulse appears and busy stays high.

// File: rtl/jtag_bscan_watch.sv
module jtag_bscan_watch #(
  parameter int IR_MAX  = 10,
  parameter int BSR_MAX = 1488,
  parameter int DIV     = 2,
  parameter int IDW     = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cmd_valid,
  input  logic [2:0]                   cmd,
  input  logic [IR_MAX-1:0]            cfg_opcode,
  input  logic [$clog2(IR_MAX+1)-1:0]  cfg_ir_len,
  input  logic [$clog2(BSR_MAX+1)-1:0] cfg_bsr_len,
  output logic                         busy,
  output logic                         tck,
  output logic                         tms,
  output logic                         tdi,
  input  logic                         tdo,
  output logic                         ev_valid,
  input  logic                         ev_ready,
  output logic [$clog2(BSR_MAX)-1:0]   ev_idx,
  output logic [IDW-1:0]               idcode,
  output logic                         id_valid
);
  localparam int IW = $clog2(BSR_MAX);
  localparam int LW = $clog2(BSR_MAX+1);
  localparam int OW = $clog2(IR_MAX);
  localparam int CW = (LW > 7) ? LW : 7;
  localparam int DW = $clog2(DIV+1);
  localparam logic [2:0] C_INFO = 3'd1, C_MON = 3'd2, C_LRN = 3'd3, C_LIST = 3'd4, C_STOP = 3'd5;

  typedef enum logic [2:0] {S_OFF, S_RST, S_GIR, S_SIR, S_UPD, S_GDR, S_SDR, S_LST} st_t;
  typedef enum logic [1:0] {M_INFO, M_MON, M_LRN} md_t;

  st_t            st;
  md_t            md;
  logic [CW-1:0]  cnt, seg_len;
  logic [DW-1:0]  dcnt;
  logic           seeded;
  logic [BSR_MAX-1:0] prev, lock;
  logic [IDW-1:0] id_sh;

  wire [IW-1:0] widx    = cnt[IW-1:0];
  wire          last    = (cnt == seg_len - CW'(1));
  wire          running = (st != S_OFF) && (st != S_LST);
  wire          tick    = running && !ev_valid && (dcnt == DW'(DIV-1));
  wire          rise    = tick && !tck;
  wire          fall    = tick && tck;
  wire          chg     = seeded && (prev[widx] ^ tdo) && !lock[widx];

  assign busy = (st != S_OFF);
  assign tdi  = (st == S_SIR) && cfg_opcode[cnt[OW-1:0]];

  always_comb begin
    case (st)
      S_RST:   seg_len = CW'(6);
      S_GIR:   seg_len = CW'(4);
      S_SIR:   seg_len = CW'(cfg_ir_len);
      S_UPD:   seg_len = CW'(2);
      S_GDR:   seg_len = CW'(3);
      S_SDR:   seg_len = (md == M_INFO) ? CW'(IDW) : CW'(cfg_bsr_len);
      default: seg_len = CW'(1);
    endcase
    case (st)
      S_RST:        tms = cnt < CW'(5);
      S_GIR:        tms = cnt < CW'(2);
      S_SIR, S_SDR: tms = last;
      S_UPD, S_GDR: tms = (cnt == '0);
      default:      tms = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_OFF; md <= M_INFO; cnt <= '0; dcnt <= '0; tck <= 1'b0;
      seeded <= 1'b0; prev <= '0; lock <= '0; id_sh <= '0;
      ev_valid <= 1'b0; ev_idx <= '0; idcode <= '0; id_valid <= 1'b0;
    end else begin
      id_valid <= 1'b0;
      if (ev_valid && ev_ready) ev_valid <= 1'b0;
      if (running && !ev_valid) dcnt <= (dcnt == DW'(DIV-1)) ? '0 : dcnt + DW'(1);
      if (tick) tck <= ~tck;

      if (rise && st == S_SDR) begin
        if (md == M_INFO) begin
          id_sh <= {tdo, id_sh[IDW-1:1]};
          if (last) begin
            idcode   <= {tdo, id_sh[IDW-1:1]};
            id_valid <= 1'b1;
          end
        end else begin
          prev[widx] <= tdo;
          if (chg) begin
            ev_valid <= 1'b1;
            ev_idx   <= widx;
            if (md == M_LRN) lock[widx] <= 1'b1;
          end
          if (last) seeded <= 1'b1;
        end
      end

      if (fall) begin
        if (!last) cnt <= cnt + CW'(1);
        else begin
          cnt <= '0;
          case (st)
            S_RST:   st <= (md == M_INFO) ? S_GDR : S_GIR;
            S_GIR:   st <= S_SIR;
            S_SIR:   st <= S_UPD;
            S_GDR:   st <= S_SDR;
            S_SDR:   st <= S_UPD;
            S_UPD:   st <= (md == M_INFO) ? S_OFF : S_GDR;
            default: st <= S_OFF;
          endcase
        end
      end

      if (st == S_LST && !ev_valid) begin
        if (lock[widx]) begin
          ev_valid <= 1'b1;
          ev_idx   <= widx;
        end
        if (cnt == CW'(cfg_bsr_len) - CW'(1)) st <= S_OFF;
        else cnt <= cnt + CW'(1);
      end

      if (cmd_valid) begin
        if (cmd == C_STOP) begin
          st  <= S_OFF;
          tck <= 1'b0;
        end else if (st == S_OFF) begin
          cnt  <= '0;
          dcnt <= '0;
          case (cmd)
            C_INFO: begin md <= M_INFO; st <= S_RST; end
            C_MON:  begin md <= M_MON;  st <= S_RST; seeded <= 1'b0; end
            C_LRN:  begin md <= M_LRN;  st <= S_RST; seeded <= 1'b0; end
            C_LIST: st <= S_LST;
            default: ;
          endcase
        end
      end
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && !ev_ready) |=> (ev_valid && $stable(ev_idx))); // R8
  AST_TCK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && !ev_ready && !cmd_valid) |=> $stable(tck)); // R8
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |-> (LW'(ev_idx) < cfg_bsr_len)); // R5
  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd == C_STOP) |=> (!busy && !tck)); // R10
  AST_IDLE_TCK: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !tck); // R1
endmodule

// File: tb/jtag_bscan_watch_bench.sv
module jtag_bscan_watch_bench;
  localparam logic [9:0]  OP_SMP = 10'b0000000101;
  localparam logic [9:0]  OP_ID  = 10'b0000000110;
  localparam logic [31:0] ID_VAL = 32'h1234_5AB7;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, cmd_valid = 1'b0, ev_ready = 1'b1;
  logic [2:0] cmd = 3'd0;
  logic [9:0] cfg_opcode = OP_SMP;
  logic [3:0] cfg_ir_len = 4'd10;
  logic [10:0] cfg_bsr_len = 11'd16;
  logic busy, tck, tms, tdi, ev_valid, id_valid;
  logic tdo_m = 1'b0;
  logic [10:0] ev_idx;
  logic [31:0] idcode;

  jtag_bscan_watch u_jtag_bscan_watch (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd),
    .cfg_opcode(cfg_opcode), .cfg_ir_len(cfg_ir_len), .cfg_bsr_len(cfg_bsr_len),
    .busy(busy), .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo_m),
    .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_idx(ev_idx),
    .idcode(idcode), .id_valid(id_valid));

  typedef enum logic [3:0] {TLR, RTI, SDS, CDR, SHD, E1D, PDR, E2D, UDR,
                            SIS, CIR, SHI, E1I, PIR, E2I, UIR} tap_t;
  tap_t ts = TLR;
  logic [9:0] ir = OP_ID, irs = '0, ir_upd = '0;
  logic [31:0] dsr = '0, pins = '0;
  int blen = 16, cap_cnt = 0, id_cnt = 0;
  logic auto_tog = 1'b0;

  function automatic tap_t nxt(tap_t s, logic m);
    case (s)
      TLR: return m ? TLR : RTI;
      RTI: return m ? SDS : RTI;
      SDS: return m ? SIS : CDR;
      CDR: return m ? E1D : SHD;
      SHD: return m ? E1D : SHD;
      E1D: return m ? UDR : PDR;
      PDR: return m ? E2D : PDR;
      E2D: return m ? UDR : SHD;
      UDR: return m ? SDS : RTI;
      SIS: return m ? TLR : CIR;
      CIR: return m ? E1I : SHI;
      SHI: return m ? E1I : SHI;
      E1I: return m ? UIR : PIR;
      PIR: return m ? E2I : PIR;
      E2I: return m ? UIR : SHI;
      default: return m ? SDS : RTI;
    endcase
  endfunction

  function automatic int dlen();
    return (ir == OP_ID) ? 32 : (ir == OP_SMP) ? blen : 1;
  endfunction

  always @(posedge tck) begin
    case (ts)
      TLR: ir <= OP_ID;
      CDR: begin
        if (ir == OP_ID) dsr <= ID_VAL;
        else if (ir == OP_SMP) begin
          dsr <= pins & ((32'd1 << blen) - 32'd1);
          cap_cnt <= cap_cnt + 1;
        end else dsr <= '0;
      end
      SHD: dsr <= (dsr >> 1) | (32'(tdi) << (dlen() - 1));
      CIR: irs <= 10'b1;
      SHI: irs <= {tdi, irs[9:1]};
      UIR: begin ir <= irs; ir_upd <= irs; end
      default: ;
    endcase
    ts <= nxt(ts, tms);
  end
  always @(negedge tck) tdo_m <= (ts == SHD) ? dsr[0] : (ts == SHI) ? irs[0] : 1'b0;
  always @(cap_cnt) if (auto_tog) pins = pins ^ 32'h8;

  int evq[$], expq[$];
  always @(negedge clk) begin
    if (ev_valid && ev_ready) evq.push_back(int'(ev_idx));
    if (id_valid) id_cnt++;
  end

  int total = 0, bad = 0;
  task automatic chk(string r, longint act, longint exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", r, act, exp);
    end
  endtask

  task automatic chkq(string r);
    chk({r, " count"}, evq.size(), expq.size());
    for (int i = 0; i < evq.size() && i < expq.size(); i++)
      chk({r, " index"}, evq[i], expq[i]);
  endtask

  task automatic send(logic [2:0] c);
    @(negedge clk); cmd_valid = 1'b1; cmd = c;
    @(negedge clk); cmd_valid = 1'b0;
  endtask

  task automatic wait_cap(int n);
    wait (cap_cnt >= n);
    @(negedge clk);
  endtask

  task automatic stop_drain();
    send(3'd5);
    chk("R10 stop busy", busy, 0);
    chk("R10 stop tck", tck, 0);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 tck", tck, 0);
    chk("R1 ev_valid", ev_valid, 0);
    evq.delete(); expq.delete();
    send(3'd4);
    wait (!busy); repeat (3) @(negedge clk);
    chkq("R1 empty mask");
  endtask

  task automatic t_info();
    send(3'd1);
    wait (id_cnt == 1); @(negedge clk);
    chk("R2 idcode", idcode, ID_VAL);
    wait (!busy); @(negedge clk);
    chk("R2 ends idle", ts, RTI);
  endtask

  task automatic t_monitor();
    int base;
    pins = 32'hA5C3; evq.delete(); expq.delete();
    base = cap_cnt;
    send(3'd2);
    wait_cap(base + 2);
    chk("R3 opcode loaded", ir_upd, OP_SMP);
    chk("R4 seed silent", evq.size(), 0);
    pins = pins ^ 32'h8021;
    send(3'd1);
    repeat (5) @(negedge clk);
    chk("R10 busy kept", busy, 1);
    wait_cap(base + 4);
    chk("R10 info ignored", id_cnt, 1);
    stop_drain();
    expq.push_back(0); expq.push_back(5); expq.push_back(15);
    chkq("R5 changes");
  endtask

  task automatic t_stall();
    int base; logic t0; logic [10:0] i0;
    evq.delete(); expq.delete();
    ev_ready = 1'b0;
    base = cap_cnt;
    send(3'd2);
    wait_cap(base + 1);
    pins = pins ^ 32'h0300;
    wait (ev_valid); @(negedge clk);
    t0 = tck; i0 = ev_idx;
    repeat (40) @(negedge clk);
    chk("R8 valid held", ev_valid, 1);
    chk("R8 tck held", tck, t0);
    chk("R8 idx held", ev_idx, i0);
    ev_ready = 1'b1;
    wait_cap(base + 3);
    stop_drain();
    expq.push_back(8); expq.push_back(9);
    chkq("R8 nothing lost");
  endtask

  task automatic t_learn();
    int base;
    evq.delete(); expq.delete();
    auto_tog = 1'b1;
    base = cap_cnt;
    send(3'd3);
    wait_cap(base + 2);
    pins = pins ^ 32'h80;
    wait_cap(base + 5);
    stop_drain();
    expq.push_back(3); expq.push_back(7);
    chkq("R6 learn once");
    evq.delete();
    send(3'd4);
    wait (!busy); repeat (3) @(negedge clk);
    chkq("R7 list");
    evq.delete(); expq.delete();
    base = cap_cnt;
    send(3'd2);
    wait_cap(base + 2);
    pins = pins ^ 32'h280;
    wait_cap(base + 4);
    stop_drain();
    auto_tog = 1'b0;
    expq.push_back(9);
    chkq("R6 masked silent");
  endtask

  task automatic t_len();
    int base;
    blen = 12; cfg_bsr_len = 11'd12;
    evq.delete(); expq.delete();
    base = cap_cnt;
    send(3'd2);
    wait_cap(base + 2);
    pins = pins ^ 32'h4804;
    wait_cap(base + 4);
    stop_drain();
    expq.push_back(2); expq.push_back(11);
    chkq("R9 short length");
  endtask

  task automatic t_opcode();
    cfg_opcode = 10'b1011000101;
    send(3'd2);
    repeat (400) @(negedge clk);
    chk("R3 runtime opcode", ir_upd, 10'b1011000101);
    stop_drain();
    cfg_opcode = OP_SMP;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    fork
      begin
        t_reset(); t_info(); t_monitor(); t_stall();
        t_learn(); t_len(); t_opcode();
      end
      begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=expired exp=done");
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule